// File: doc/BRIEF.md
# Front-End Register Initialisation Sequencer

This block brings a readout front end from power-up into a usable state. It does so through a simple register-write bus. A single start pulse launches a fixed series of writes. The first eight go to the converter-card register bank. They hold every front-end chip in reset, power up the channel circuitry, clear the equaliser settings and set the clock and trigger output enables. The last of them releases the reset, so the chips see a clean reset pulse. Next comes a broadcast write of the chip default word to every front-end chip. After it, a synchronous-reset command goes to the application port. This command restarts the chips' PLL and readout logic.

The sequence can end with a broadcast PLL fine-delay write, which carries a programmable phase value. This write is present only when its enable is high. Each write is offered with a strobe and held unchanged until the target acknowledges it. `busy_o` is high for the whole sequence, and `done_o` pulses once after the last write. The enable, the phase value and the default word are captured when the sequence starts.

Top module: `fe_init_seq`

## Requirements
- R1: While reset is applied, and after it until a start is accepted, `wr_valid_o`, `busy_o` and `done_o` are all low.
- R2: A start pulse seen while idle presents the first write in the next cycle: port code 0 (converter card), address 0x00, data 0x00. This write asserts the active-low chip reset.
- R3: The converter-card writes, all with port code 0, follow a fixed order: addresses 0x01, 0x02, 0x03, 0x04 and 0x05 with data 0x00, then address 0x06 with data 0xFF, then address 0x00 with data 0xFF (reset released).
- R4: The ninth write uses port code 1 (chip broadcast) and address 0xFF03, and carries the default word captured at start.
- R5: The tenth write uses port code 2 (application port) and the all-ones address, and carries data 0x0001.
- R6: When the captured enable is high, an eleventh write follows with port code 1, address 0xFF00 and the captured phase value zero-extended as data. When it is low, the sequence ends after the tenth write.
- R7: A write keeps `wr_valid_o`, port, address and data unchanged until a cycle where `ack_i` is high. The following write, if any, appears in the next cycle.
- R8: `busy_o` is high from the cycle after the accepted start through the cycle of the final acknowledge. `done_o` is a single-cycle pulse in the following cycle, while `busy_o` is low.
- R9: A start pulse during a sequence has no effect, and an `ack_i` while no write is offered has no effect.
- R10: Changes to the enable, phase value or default word after the start has been accepted do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| phase_en_i | input | 1 | Enables the final fine-delay write |
| phase_val_i | input | PHASE_W | Fine-delay phase value |
| dflt_word_i | input | DATA_W | Chip default word for the broadcast write |
| ack_i | input | 1 | Write acknowledge from the bus |
| wr_valid_o | output | 1 | Write strobe, held until acknowledged |
| wr_port_o | output | 2 | Target port: 0 card, 1 chip broadcast, 2 application |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The assertions check four behaviours on every cycle: an unacknowledged write stays stable, the first write follows an idle start, the resync write has its fixed address and data, and `done_o` is a lone pulse that follows a final acknowledge. The full write order, the optional phase write, the input capture at start, and the effect of ignored starts and stray acknowledges come only from the bench scenarios. In those scenarios a behavioural queue model predicts every output on every clock, under several acknowledge rhythms.

// File: rtl/fe_init_pkg.sv
package fe_init_pkg;
  typedef enum logic [1:0] {
    PORT_CARD = 2'd0,
    PORT_CHIP = 2'd1,
    PORT_APP  = 2'd2
  } port_e;

  localparam int STEP_W         = 4;
  localparam int CARD_WRITES    = 8;  // steps 0..7
  localparam int CLK_EN_STEP    = 6;  // first card write carrying 0xFF
  localparam int CHIP_DFLT_STEP = 8;
  localparam int RESYNC_STEP    = 9;
  localparam int PHASE_STEP     = 10;
  localparam logic [15:0] CHIP_DFLT_SUB = 16'hFF03;
  localparam logic [15:0] CHIP_PLL_SUB  = 16'hFF00;
endpackage

// File: rtl/fe_init_rstsync.sv
module fe_init_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/fe_init_rom.sv
module fe_init_rom
  import fe_init_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int PHASE_W = 8
) (
  input  logic [STEP_W-1:0]  step_i,
  input  logic [DATA_W-1:0]  dflt_i,
  input  logic [PHASE_W-1:0] phase_i,
  output port_e              port_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  data_o
);
  localparam logic [STEP_W-1:0] LAST_CARD = STEP_W'(CARD_WRITES - 1);

  always_comb begin
    port_o = PORT_CARD;
    addr_o = '0;
    data_o = '0;
    if (step_i < STEP_W'(CARD_WRITES)) begin
      // card bank: reset asserted first, released last
      addr_o = (step_i == LAST_CARD) ? '0 : ADDR_W'(step_i);
      data_o = (step_i >= STEP_W'(CLK_EN_STEP)) ? DATA_W'(8'hFF) : '0;
    end else if (step_i == STEP_W'(CHIP_DFLT_STEP)) begin
      port_o = PORT_CHIP;
      addr_o = ADDR_W'(CHIP_DFLT_SUB);
      data_o = dflt_i;
    end else if (step_i == STEP_W'(RESYNC_STEP)) begin
      port_o = PORT_APP;
      addr_o = '1;
      data_o = DATA_W'(1);
    end else begin
      port_o = PORT_CHIP;
      addr_o = ADDR_W'(CHIP_PLL_SUB);
      data_o = DATA_W'(phase_i);
    end
  end
endmodule

// File: rtl/fe_init_ctrl.sv
module fe_init_ctrl
  import fe_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              phase_en_i,
  input  logic              ack_i,
  output logic              accept_o,
  output logic              active_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o
);
  typedef enum logic {ST_IDLE, ST_WRITE} state_e;

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              en_q, en_d;
  logic              last_step;

  assign last_step = (step_q == STEP_W'(PHASE_STEP)) ||
                     ((step_q == STEP_W'(RESYNC_STEP)) && !en_q);

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    en_d     = en_q;
    done_d   = 1'b0;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_WRITE;
          step_d   = '0;
          en_d     = phase_en_i;
        end
      end
      ST_WRITE: begin
        if (ack_i) begin
          if (last_step) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      en_q    <= en_d;
    end
  end

  assign active_o = (state_q == ST_WRITE);
  assign done_o   = done_q;
  assign step_o   = step_q;
endmodule

// File: rtl/fe_init_seq.sv
module fe_init_seq
  import fe_init_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               phase_en_i,
  input  logic [PHASE_W-1:0] phase_val_i,
  input  logic [DATA_W-1:0]  dflt_word_i,
  input  logic               ack_i,
  output logic               wr_valid_o,
  output logic [1:0]         wr_port_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               busy_o,
  output logic               done_o
);
  logic               rst_sync_n;
  logic               accept;
  logic               active;
  logic [STEP_W-1:0]  step;
  logic [PHASE_W-1:0] phase_q;
  logic [DATA_W-1:0]  dflt_q;
  port_e              port_w;

  fe_init_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fe_init_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .phase_en_i (phase_en_i),
    .ack_i      (ack_i),
    .accept_o   (accept),
    .active_o   (active),
    .done_o     (done_o),
    .step_o     (step)
  );

  // operands captured when the sequence is accepted
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= '0;
      dflt_q  <= '0;
    end else if (accept) begin
      phase_q <= phase_val_i;
      dflt_q  <= dflt_word_i;
    end
  end

  fe_init_rom #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PHASE_W (PHASE_W)
  ) u_rom (
    .step_i  (step),
    .dflt_i  (dflt_q),
    .phase_i (phase_q),
    .port_o  (port_w),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o)
  );

  assign wr_port_o  = port_w;
  assign wr_valid_o = active;
  assign busy_o     = active;
endmodule

// File: rtl/fe_init_seq_chk.sv
module fe_init_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ack_i,
  input logic              wr_valid_o,
  input logic [1:0]        wr_port_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_valid_o && !ack_i) |=> (wr_valid_o && $stable(wr_port_o) &&
                                $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (wr_valid_o && wr_port_o == 2'd0 &&
                              wr_addr_o == '0 && wr_data_o == '0));

  assert_resync_word_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_valid_o && wr_port_o == 2'd2) |-> (wr_addr_o == '1 && wr_data_o == DATA_W'(1)));

  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(wr_valid_o && ack_i)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind fe_init_seq fe_init_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .start_i    (start_i),
  .ack_i      (ack_i),
  .wr_valid_o (wr_valid_o),
  .wr_port_o  (wr_port_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/fe_init_seq_bench.sv
module fe_init_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        phase_en_i;
  logic [7:0]  phase_val_i;
  logic [31:0] dflt_word_i;
  logic        ack_i;
  logic        wr_valid_o;
  logic [1:0]  wr_port_o;
  logic [31:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic        busy_o;
  logic        done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_init_seq u_fe_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_en_i(phase_en_i),
    .phase_val_i(phase_val_i), .dflt_word_i(dflt_word_i), .ack_i(ack_i),
    .wr_valid_o(wr_valid_o), .wr_port_o(wr_port_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // ---------------- reference model ----------------
  typedef struct { int port; logic [31:0] addr; logic [31:0] data; } wr_t;
  wr_t m_q[$];
  int  m_total = 0;
  bit  m_busy = 0;
  bit  m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_q.delete();
          for (int a = 0; a < 6; a++) m_q.push_back('{0, 32'(a), 32'h0});
          m_q.push_back('{0, 32'h6, 32'hFF});
          m_q.push_back('{0, 32'h0, 32'hFF});
          m_q.push_back('{1, 32'hFF03, dflt_word_i});
          m_q.push_back('{2, 32'hFFFF_FFFF, 32'h1});
          if (phase_en_i) m_q.push_back('{1, 32'hFF00, {24'h0, phase_val_i}});
          m_total = m_q.size();
          m_busy = 1;
        end
      end else if (ack_i) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  function automatic string tag_of(int idx);
    if (idx == 0) return "R2";
    if (idx < 8)  return "R3";
    if (idx == 8) return "R4";
    if (idx == 9) return "R5";
    return "R6";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check("R8", "busy", 32'(busy_o), 32'(m_busy));
      check("R8", "done", 32'(done_o), 32'(m_done));
      check("R7", "strobe", 32'(wr_valid_o), 32'(m_busy));
      if (m_busy && wr_valid_o) begin
        string t;
        t = tag_of(m_total - m_q.size());
        check(t, "port", 32'(wr_port_o), 32'(m_q[0].port));
        check(t, "addr", wr_addr_o, m_q[0].addr);
        check(t, "data", wr_data_o, m_q[0].data);
      end
    end
  end

  // ---------------- observation ----------------
  int          hs_cnt = 0;
  logic [31:0] seen_dflt;
  always @(posedge clk) begin
    if (rst_n && wr_valid_o && ack_i) begin
      hs_cnt++;
      if (wr_port_o == 2'd1 && wr_addr_o == 32'hFF03) seen_dflt = wr_data_o;
    end
  end

  // ---------------- acknowledge driver ----------------
  int  ack_mode = 0;  // 0: always, 1: every third cycle, 2: never
  bit  ack_force = 0;
  int  cyc = 0;
  always @(negedge clk) begin
    cyc++;
    ack_i <= ack_force | (ack_mode == 0) | (ack_mode == 1 && (cyc % 3 == 1));
  end

  task automatic wait_done();
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (done_o) return;
    end
  endtask

  task automatic run_seq(bit en, logic [7:0] ph, logic [31:0] dw, int mode);
    ack_mode = mode;
    phase_en_i = en; phase_val_i = ph; dflt_word_i = dw;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    hs_cnt = 0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; phase_en_i = 1'b0; phase_val_i = '0;
    dflt_word_i = '0; ack_i = 1'b0; ack_mode = 2;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 32'(busy_o), 32'h0);
    check("R1", "strobe in reset", 32'(wr_valid_o), 32'h0);
    check("R1", "done in reset", 32'(done_o), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "idle after reset", {busy_o, wr_valid_o, done_o}, 32'h0);

    // R9: stray acknowledges while idle
    ack_force = 1;
    repeat (3) @(negedge clk);
    ack_force = 0;
    check("R9", "idle ack strobe", 32'(wr_valid_o), 32'h0);
    check("R9", "idle ack busy", 32'(busy_o), 32'h0);

    // full sequence, phase write enabled, ack every cycle
    run_seq(1'b1, 8'h5A, 32'hA5A5_1234, 0);
    wait_done();
    check("R6", "write count with phase", 32'(hs_cnt), 32'd11);

    // back-to-back start in the done cycle, phase disabled, slow acks
    run_seq(1'b0, 8'h33, 32'h0BAD_F00D, 1);
    wait_done();
    check("R6", "write count without phase", 32'(hs_cnt), 32'd10);

    // R7: long stall with no ack
    repeat (2) @(negedge clk);
    run_seq(1'b1, 8'hC3, 32'h1357_9BDF, 2);
    repeat (10) @(negedge clk);
    check("R7", "stalled strobe", 32'(wr_valid_o), 32'h1);
    check("R7", "stalled addr", wr_addr_o, 32'h0);
    ack_mode = 1;
    // R9 and R10: restart attempts and input changes mid-sequence
    repeat (4) @(negedge clk);
    start_i = 1'b1; phase_en_i = 1'b0; phase_val_i = 8'h11; dflt_word_i = 32'hDEAD_BEEF;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check("R9", "writes despite restart", 32'(hs_cnt), 32'd11);
    check("R10", "captured default word", seen_dflt, 32'h1357_9BDF);
    @(negedge clk);
    check("R8", "idle after done", {busy_o, done_o}, 32'h0);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    finish_run();
  end
endmodule